// File: doc/BRIEF.md
# USB IN Endpoint Handshake Controller

This block keeps the control and status state of a single USB device IN endpoint and picks the handshake when the host sends an IN token. A CPU writes and reads an 8-bit control/status register. It tells the block that a packet has been loaded into the packet buffer, and the block counts how many loaded packets are waiting. The buffer holds one packet, or two when double buffering is on. The serial engine sends three single-cycle events: a received IN token, a start-of-frame, and a completed data transmission. The block answers every IN token with a registered response code and shows the current data toggle.

In bulk/interrupt mode a token gets STALL if stalling is requested. Otherwise it gets a DATA0/DATA1 packet if a packet is waiting, or NAK if none is. In isochronous mode the stall request is ignored, the toggle stays at DATA0, and an empty endpoint sends a zero-length packet. A per-endpoint option holds each newly loaded isochronous packet back until the next start-of-frame. The block drives one-cycle pulses to the buffer memory when it must drop the head packet or clear everything. It also raises an interrupt pulse after each completed transmission.

Register bits: bit 0 packet ready (write 1 = a packet was loaded), bit 1 buffer not empty (read only), bit 2 underrun flag (write 1 clears), bit 3 flush (write 1 starts a flush), bit 4 stall request (read/write), bit 5 stall-sent flag (write 1 clears), bit 6 toggle clear (write 1 clears the toggle, reads 0), bit 7 reads 0. Response codes on `resp_code`: 1 = DATA0, 2 = DATA1, 3 = NAK, 4 = STALL, 5 = zero-length packet.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset `reg_rdata` reads 0x00 and `data_tgl` is 0. Bits 7 and 6 always read 0, bit 1 reads 1 exactly when at least one loaded packet waits, and bit 4 reads back the last value written to it.
- R2: Writing a 1 to bit 6 sets the data toggle to 0 from the next cycle on.
- R3: An IN token that gets STALL sets bit 5, empties the buffer (bits 1 and 0 read 0), and pulses `buf_clear` in the same cycle as the response. Bit 5 stays set until a write with bit 5 = 1, and writing 0 to bit 4 makes later tokens get NAK.
- R4: In isochronous mode bit 4 has no effect: a token gets data or a zero-length packet, never STALL.
- R5: Writing 1 to bit 3 makes bit 3 read 1 for one cycle. The head packet is then discarded, bit 3 returns to 0, the ready bit clears, and `buf_drop` pulses for one cycle.
- R6: In bulk/interrupt mode every token answered with NAK sets bit 2. Writing 1 to bit 2 clears it.
- R7: In isochronous mode a token that finds no packet ready is answered with a zero-length packet (code 5) and sets bit 2.
- R8: With single buffering, writing 1 to bit 0 makes bits 0 and 1 read 1. A completed transmission (`tx_done`) clears both.
- R9: With double buffering, bit 0 reads 0 while one packet waits and a slot is free. It reads 1 once both slots are loaded, and 0 again after one transmission.
- R10: In isochronous mode with `iso_sof_hold` set, a newly loaded packet reads as not ready (bit 0 = 0) and cannot be sent until the next `sof` pulse. A token before that pulse gets a zero-length packet.
- R11: `irq` pulses for one cycle, one cycle after each completed transmission, only while `irq_en` is 1.
- R12: In bulk/interrupt mode the toggle flips after each completed transmission, and data responses alternate DATA0/DATA1. In isochronous mode every data response is DATA0.
- R13: When several conditions hold at a token, STALL wins over a ready packet, and a ready packet wins over NAK or zero-length.
- R14: `resp_valid` pulses exactly one cycle after each `tok_in` pulse and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iso_mode | input | 1 | 1 = isochronous, 0 = bulk/interrupt |
| dbl_buf | input | 1 | 1 = two packet slots |
| iso_sof_hold | input | 1 | Hold new isochronous packets until the next SOF |
| irq_en | input | 1 | Interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| tok_in | input | 1 | IN token received (one-cycle pulse) |
| sof | input | 1 | Start of frame (one-cycle pulse) |
| tx_done | input | 1 | Data packet transmission completed |
| resp_valid | output | 1 | Response code valid |
| resp_code | output | 3 | Response: 1 DATA0, 2 DATA1, 3 NAK, 4 STALL, 5 zero-length |
| data_tgl | output | 1 | Current data toggle |
| irq | output | 1 | Transmit-complete interrupt pulse |
| buf_drop | output | 1 | Discard the head packet and reset the read pointer |
| buf_clear | output | 1 | Discard all buffered packets |

## Verification
Every result comes from a register, so each one is due one clock edge after its cause. The response code, `irq`, `buf_clear` and `buf_drop` appear on the edge after `tok_in`, `tx_done` or the flush start. The register bits change on the edge after the write. The flush bit reads 1 for one cycle and clears on the following edge. The bench drives stimulus on falling edges and samples at the next falling edge, so each check falls half a cycle after the edge that is due to produce its value. Responses are pushed to a queue by the token driver and popped by a monitor that compares them, and an extra `resp_valid` that nothing expects is counted as a failure.

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iso_mode,
  input  logic       dbl_buf,
  input  logic       iso_sof_hold,
  input  logic       irq_en,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tok_in,
  input  logic       sof,
  input  logic       tx_done,
  output logic       resp_valid,
  output logic [2:0] resp_code,
  output logic       data_tgl,
  output logic       irq,
  output logic       buf_drop,
  output logic       buf_clear
);
  localparam logic [2:0] RSP_D0    = 3'd1;
  localparam logic [2:0] RSP_D1    = 3'd2;
  localparam logic [2:0] RSP_NAK   = 3'd3;
  localparam logic [2:0] RSP_STALL = 3'd4;
  localparam logic [2:0] RSP_ZLP   = 3'd5;

  logic [1:0] cnt, cnt_a, cnt_n, slots, avail;
  logic hold, hold_n, tgl, stall_req, stall_sent, underrun, flush_r;
  logic wr_commit, stall_act, data_act, under_act, tx_ok, fl_drop;
  logic unused_wd;

  assign unused_wd = reg_wdata[7] ^ reg_wdata[1];
  assign slots     = dbl_buf ? 2'd2 : 2'd1;
  assign avail     = cnt - {1'b0, hold};

  assign wr_commit = reg_wr & reg_wdata[0] & (cnt < slots);
  assign stall_act = tok_in & stall_req & ~iso_mode;
  assign data_act  = tok_in & ~stall_act & (avail != 2'd0);
  assign under_act = tok_in & ~stall_act & ~data_act;
  assign tx_ok     = tx_done & (avail != 2'd0) & ~stall_act;

  assign cnt_a   = cnt + {1'b0, wr_commit} - {1'b0, tx_ok};
  assign fl_drop = flush_r & (cnt_a != 2'd0);
  assign cnt_n   = stall_act ? 2'd0 : cnt_a - {1'b0, fl_drop};

  always_comb begin
    hold_n = hold;
    if (sof) hold_n = 1'b0;
    if (wr_commit && iso_mode && iso_sof_hold) hold_n = 1'b1;
    if (cnt_n == 2'd0) hold_n = 1'b0;
  end

  assign reg_rdata = {2'b00, stall_sent, stall_req, flush_r, underrun,
                      cnt != 2'd0, (cnt == slots) & ~hold};
  assign data_tgl  = tgl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= 2'd0;
      hold       <= 1'b0;
      tgl        <= 1'b0;
      stall_req  <= 1'b0;
      stall_sent <= 1'b0;
      underrun   <= 1'b0;
      flush_r    <= 1'b0;
      resp_valid <= 1'b0;
      resp_code  <= 3'd0;
      irq        <= 1'b0;
      buf_drop   <= 1'b0;
      buf_clear  <= 1'b0;
    end else begin
      cnt        <= cnt_n;
      hold       <= hold_n;
      stall_sent <= stall_act | (stall_sent & ~(reg_wr & reg_wdata[5]));
      underrun   <= under_act | (underrun & ~(reg_wr & reg_wdata[2]));
      flush_r    <= reg_wr & reg_wdata[3];
      if (reg_wr) stall_req <= reg_wdata[4];
      if ((reg_wr && reg_wdata[6]) || iso_mode) tgl <= 1'b0;
      else if (tx_ok)                            tgl <= ~tgl;
      resp_valid <= tok_in;
      if (stall_act)     resp_code <= RSP_STALL;
      else if (data_act) resp_code <= tgl ? RSP_D1 : RSP_D0;
      else if (iso_mode) resp_code <= RSP_ZLP;
      else               resp_code <= RSP_NAK;
      irq       <= tx_ok & irq_en;
      buf_drop  <= fl_drop;
      buf_clear <= stall_act;
    end
  end

  // R14
  resp_after_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(tok_in));

  // R3
  stall_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == RSP_STALL) |-> (reg_rdata[5] && !reg_rdata[1] && buf_clear));

  // R4
  iso_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(iso_mode)) |-> resp_code != RSP_STALL);

  // R6
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_code == RSP_NAK || resp_code == RSP_ZLP)) |-> reg_rdata[2]);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tx_done && irq_en));

  // R5
  flush_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[3] && !(reg_wr && reg_wdata[3])) |=> !reg_rdata[3]);

  // R12
  iso_data0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(iso_mode) && $past(iso_mode, 2)) |-> resp_code != RSP_D1);
endmodule

// File: tb/test_usb_in_ep_ctrl.sv
module test_usb_in_ep_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic iso_mode = 0, dbl_buf = 0, iso_sof_hold = 0, irq_en = 1;
  logic reg_wr = 0, tok_in = 0, sof = 0, tx_done = 0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic resp_valid, data_tgl, irq, buf_drop, buf_clear;
  logic [2:0] resp_code;

  int n_chk = 0, n_fail = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  usb_in_ep_ctrl i_usb_in_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .iso_mode(iso_mode), .dbl_buf(dbl_buf),
    .iso_sof_hold(iso_sof_hold), .irq_en(irq_en), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_in(tok_in), .sof(sof),
    .tx_done(tx_done), .resp_valid(resp_valid), .resp_code(resp_code),
    .data_tgl(data_tgl), .irq(irq), .buf_drop(buf_drop), .buf_clear(buf_clear));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) chk({5'd0, resp_code}, 8'hFF, "R14 unexpected response");
      else chk({5'd0, resp_code}, {5'd0, exp_q.pop_front()}, tag_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0; reg_wdata = 8'h00;
  endtask

  task automatic tok(input logic [2:0] code, input string tag);
    exp_q.push_back(code); tag_q.push_back(tag);
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
    chk({7'd0, resp_valid}, 8'd1, "R14 response due one cycle after token");
  endtask

  task automatic txd(input logic exp_irq, input string tag);
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    chk({7'd0, irq}, {7'd0, exp_irq}, tag);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reg_rdata, 8'h00, "R1 reset register");
    chk({7'd0, data_tgl}, 8'd0, "R1 reset toggle");

    // bulk, single buffer: NAK and underrun
    tok(3'd3, "R6 empty bulk NAK");
    chk(reg_rdata & 8'h04, 8'h04, "R6 underrun set");
    wr(8'h04);
    chk(reg_rdata & 8'h04, 8'h00, "R6 underrun cleared");

    // load, send, toggle
    wr(8'h01);
    chk(reg_rdata, 8'h03, "R8 ready and not empty");
    tok(3'd1, "R12 first DATA0");
    txd(1'b1, "R11 irq after transmit");
    @(negedge clk);
    chk({7'd0, irq}, 8'd0, "R11 irq one cycle");
    chk(reg_rdata & 8'h03, 8'h00, "R8 cleared by transmit");
    chk({7'd0, data_tgl}, 8'd1, "R12 toggle flipped");
    wr(8'h01);
    tok(3'd2, "R12 DATA1");
    txd(1'b1, "R11 irq second");
    chk({7'd0, data_tgl}, 8'd0, "R12 toggle back");
    wr(8'h01);
    tok(3'd1, "R12 DATA0 again");
    txd(1'b1, "R11 irq third");
    wr(8'h40);
    chk({7'd0, data_tgl}, 8'd0, "R2 toggle cleared");
    chk(reg_rdata & 8'hC0, 8'h00, "R1 bits 7 and 6 read 0");

    // flush
    wr(8'h01);
    wr(8'h08);
    chk(reg_rdata & 8'h0B, 8'h0B, "R5 flush bit set, packet present");
    @(negedge clk);
    chk(reg_rdata & 8'h0B, 8'h00, "R5 flush done, buffer empty");
    chk({7'd0, buf_drop}, 8'd1, "R5 buf_drop pulse");
    @(negedge clk);
    chk({7'd0, buf_drop}, 8'd0, "R5 buf_drop one cycle");

    // stall with packet ready
    wr(8'h11);
    chk(reg_rdata & 8'h13, 8'h13, "R1 stall bit reads back");
    tok(3'd4, "R13 stall wins over data");
    chk(reg_rdata & 8'h23, 8'h20, "R3 stall sent, buffer emptied");
    chk({7'd0, buf_clear}, 8'd1, "R3 buf_clear pulse");
    wr(8'h10);
    chk(reg_rdata & 8'h30, 8'h30, "R3 stall flag sticky");
    wr(8'h30);
    chk(reg_rdata & 8'h30, 8'h10, "R3 stall flag cleared by write");
    wr(8'h00);
    tok(3'd3, "R3 NAK after stall off");

    // double buffering
    dbl_buf = 1;
    wr(8'h01);
    chk(reg_rdata & 8'h03, 8'h02, "R9 one loaded, slot free");
    wr(8'h01);
    chk(reg_rdata & 8'h03, 8'h03, "R9 both slots loaded");
    tok(3'd1, "R13 data before NAK");
    txd(1'b1, "R11 irq double");
    chk(reg_rdata & 8'h03, 8'h02, "R9 one left");
    tok(3'd2, "R12 second packet DATA1");
    txd(1'b1, "R11 irq double second");
    chk(reg_rdata & 8'h03, 8'h00, "R9 empty");
    dbl_buf = 0;

    // isochronous
    iso_mode = 1;
    wr(8'h14);
    tok(3'd5, "R7 iso empty zero-length");
    chk(reg_rdata & 8'h24, 8'h04, "R7 underrun set, no stall sent");
    wr(8'h15);
    tok(3'd1, "R4 iso stall ignored");
    txd(1'b1, "R11 irq iso");
    chk({7'd0, data_tgl}, 8'd0, "R12 iso toggle stays 0");
    wr(8'h01);
    tok(3'd1, "R12 iso DATA0 again");
    txd(1'b1, "R11 irq iso second");

    // iso hold until SOF
    iso_sof_hold = 1;
    wr(8'h01);
    chk(reg_rdata & 8'h03, 8'h02, "R10 held packet not ready");
    tok(3'd5, "R10 held packet not sent");
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
    chk(reg_rdata & 8'h03, 8'h03, "R10 ready after SOF");
    tok(3'd1, "R10 sent after SOF");
    txd(1'b1, "R11 irq hold");
    iso_sof_hold = 0;
    iso_mode = 0;

    // interrupt disabled
    irq_en = 0;
    wr(8'h04);
    wr(8'h01);
    tok(3'd1, "R12 bulk DATA0 after iso");
    txd(1'b0, "R11 no irq when disabled");
    @(negedge clk);
    chk({7'd0, resp_valid}, 8'd0, "R14 no spurious response");
    chk({31'd0, exp_q.size() == 0}, 8'd1, "R14 all responses seen");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule